// File: doc/BRIEF.md
# Integer Execute Unit

This block is the combinational execute stage of a 32-bit load/store integer pipeline. Each evaluation takes one instruction word and the two register operands already read for it (the value of the first source register and the value of the second), and in the same cycle produces the value to be written back, the index of the register to write, a write strobe, an arithmetic-overflow trap flag and a reserved-instruction flag.

The primary opcode sits in bits [31:26]. When it is zero, the six-bit function code in bits [5:0] picks the register-register operation. Otherwise the opcode itself names an operation with a 16-bit immediate taken from bits [15:0]. The source register fields are [25:21] and [20:16], the register-form destination is [15:11], and the shift amount is [10:6]. The block covers add and subtract in trapping and non-trapping forms, bitwise logic, signed and unsigned set-on-less-than, the three constant shifts and loading an upper immediate. The surrounding pipeline uses the write strobe to commit the result and the two flags to start an exception.

Top module: `int_exec_unit`

## Requirements
- R1: `dest_idx_o` is `instr_i[15:11]` when the opcode (`instr_i[31:26]`) is 0 and `instr_i[20:16]` otherwise, whether or not the instruction is recognised.
- R2: With opcode 0, function code 0x20 and 0x21 give `src_a_i + src_b_i` and 0x22 and 0x23 give `src_a_i - src_b_i`, all modulo 2^32.
- R3: `ovf_trap_o` is 1 only for function 0x20 (add) or 0x22 (subtract) with opcode 0, or for opcode 0x08, and only when the two's-complement result does not fit in 32 bits. Function codes 0x21 and 0x23 and opcode 0x09 never raise it.
- R4: When `ovf_trap_o` is 1, `wr_en_o` is 0, and `result_o` still carries the wrapped sum or difference.
- R5: Function 0x24 gives AND, 0x25 gives OR and 0x27 gives NOR of the two operands. Opcodes 0x0c (AND) and 0x0d (OR) combine `src_a_i` with the zero-extended immediate.
- R6: Function 0x2a and opcode 0x0a give 1 if the first operand is less than the second as two's-complement numbers, and 0 otherwise. Function 0x2b and opcode 0x0b make the same comparison on unsigned numbers. For the immediate forms, the second operand is the sign-extended immediate.
- R7: Function 0x00 shifts `src_b_i` left by `instr_i[10:6]`, filling with zeros. Function 0x02 shifts it right, filling with zeros. Function 0x03 shifts it right, filling with copies of bit 31.
- R8: Opcode 0x0f gives `{instr_i[15:0], 16'h0000}`, independent of both operands.
- R9: Opcodes 0x08 and 0x09 add `src_a_i` to the immediate sign-extended from bit 15.
- R10: An opcode or function code outside the sets above sets `bad_op_o` to 1, `wr_en_o` to 0, `ovf_trap_o` to 0 and `result_o` to 0.
- R11: A recognised instruction that does not trap drives `bad_op_o` to 0 and `wr_en_o` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | Value of the register named in [25:21] |
| src_b_i | input | 32 | Value of the register named in [20:16] |
| result_o | output | 32 | Computed write-back value |
| dest_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Commit the result to the register file |
| ovf_trap_o | output | 1 | Signed overflow on a trapping add or subtract |
| bad_op_o | output | 1 | Reserved opcode or function code |

## Verification
The hardest condition to reach is signed overflow on the trapping forms. Uniformly random operands produce it only about a quarter of the time for add, and almost never for the immediate add, because the immediate is only 16 bits wide. The stimulus therefore draws operands from a pool biased toward the most positive, most negative, zero and all-ones values, and adds directed cases at the exact wrap points. It also pairs every trapping overflow case with its non-trapping twin on identical operands, which shows that only the trapping form raises the flag.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int XLEN  = 32;
  localparam int SHW   = $clog2(XLEN);
  localparam int IMMW  = 16;
  localparam int REGW  = 5;
  localparam int CODEW = 6;

  // field positions
  localparam int OPC_LSB = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int SH_LSB  = 6;
  localparam int FN_LSB  = 0;

  localparam logic [CODEW-1:0] OPC_REGREG = 6'h00;
  localparam logic [CODEW-1:0] OPC_ADDI   = 6'h08;
  localparam logic [CODEW-1:0] OPC_ADDIU  = 6'h09;
  localparam logic [CODEW-1:0] OPC_SLTI   = 6'h0a;
  localparam logic [CODEW-1:0] OPC_SLTIU  = 6'h0b;
  localparam logic [CODEW-1:0] OPC_ANDI   = 6'h0c;
  localparam logic [CODEW-1:0] OPC_ORI    = 6'h0d;
  localparam logic [CODEW-1:0] OPC_LUI    = 6'h0f;

  localparam logic [CODEW-1:0] FN_SLL  = 6'h00;
  localparam logic [CODEW-1:0] FN_SRL  = 6'h02;
  localparam logic [CODEW-1:0] FN_SRA  = 6'h03;
  localparam logic [CODEW-1:0] FN_ADD  = 6'h20;
  localparam logic [CODEW-1:0] FN_ADDU = 6'h21;
  localparam logic [CODEW-1:0] FN_SUB  = 6'h22;
  localparam logic [CODEW-1:0] FN_SUBU = 6'h23;
  localparam logic [CODEW-1:0] FN_AND  = 6'h24;
  localparam logic [CODEW-1:0] FN_OR   = 6'h25;
  localparam logic [CODEW-1:0] FN_NOR  = 6'h27;
  localparam logic [CODEW-1:0] FN_SLT  = 6'h2a;
  localparam logic [CODEW-1:0] FN_SLTU = 6'h2b;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLTU,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_UPPER} ext_kind_e;

  typedef struct packed {
    alu_op_e   op;
    ext_kind_e ext;
    logic      use_imm;
    logic      trap_en;
    logic      reserved;
    logic      dst_is_rd;
  } ctl_t;

  function automatic logic add_overflows(input logic [XLEN-1:0] a,
                                         input logic [XLEN-1:0] b,
                                         input logic [XLEN-1:0] s);
    return (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic sub_overflows(input logic [XLEN-1:0] a,
                                         input logic [XLEN-1:0] b,
                                         input logic [XLEN-1:0] d);
    return (a[XLEN-1] != b[XLEN-1]) && (d[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic signed_less(input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
    if (a[XLEN-1] != b[XLEN-1]) return a[XLEN-1];
    return a < b;
  endfunction
endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output ctl_t            ctl_o
);
  logic [CODEW-1:0] opc;
  logic [CODEW-1:0] fn;
  assign opc = instr_i[OPC_LSB +: CODEW];
  assign fn  = instr_i[FN_LSB +: CODEW];

  always_comb begin
    ctl_o.op        = ALU_ADD;
    ctl_o.ext       = EXT_SIGN;
    ctl_o.use_imm   = 1'b0;
    ctl_o.trap_en   = 1'b0;
    ctl_o.reserved  = 1'b0;
    ctl_o.dst_is_rd = 1'b0;
    if (opc == OPC_REGREG) begin
      ctl_o.dst_is_rd = 1'b1;
      case (fn)
        FN_ADD:  begin ctl_o.op = ALU_ADD; ctl_o.trap_en = 1'b1; end
        FN_ADDU: ctl_o.op = ALU_ADD;
        FN_SUB:  begin ctl_o.op = ALU_SUB; ctl_o.trap_en = 1'b1; end
        FN_SUBU: ctl_o.op = ALU_SUB;
        FN_AND:  ctl_o.op = ALU_AND;
        FN_OR:   ctl_o.op = ALU_OR;
        FN_NOR:  ctl_o.op = ALU_NOR;
        FN_SLT:  ctl_o.op = ALU_SLT;
        FN_SLTU: ctl_o.op = ALU_SLTU;
        FN_SLL:  ctl_o.op = ALU_SLL;
        FN_SRL:  ctl_o.op = ALU_SRL;
        FN_SRA:  ctl_o.op = ALU_SRA;
        default: ctl_o.reserved = 1'b1;
      endcase
    end else begin
      ctl_o.use_imm = 1'b1;
      case (opc)
        OPC_ADDI:  begin ctl_o.op = ALU_ADD; ctl_o.trap_en = 1'b1; end
        OPC_ADDIU: ctl_o.op = ALU_ADD;
        OPC_SLTI:  ctl_o.op = ALU_SLT;
        OPC_SLTIU: ctl_o.op = ALU_SLTU;
        OPC_ANDI:  begin ctl_o.op = ALU_AND; ctl_o.ext = EXT_ZERO; end
        OPC_ORI:   begin ctl_o.op = ALU_OR;  ctl_o.ext = EXT_ZERO; end
        OPC_LUI:   begin ctl_o.op = ALU_PASSB; ctl_o.ext = EXT_UPPER; end
        default:   ctl_o.reserved = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/iexu_operand.sv
module iexu_operand
  import iexu_pkg::*;
(
  input  logic [IMMW-1:0] imm_i,
  input  ext_kind_e       ext_i,
  input  logic            use_imm_i,
  input  logic [XLEN-1:0] reg_b_i,
  output logic [XLEN-1:0] opnd_b_o
);
  localparam int PADW = XLEN - IMMW;
  logic [XLEN-1:0] imm_ext;

  always_comb begin
    case (ext_i)
      EXT_ZERO:  imm_ext = {{PADW{1'b0}}, imm_i};
      EXT_UPPER: imm_ext = {imm_i, {PADW{1'b0}}};
      default:   imm_ext = {{PADW{imm_i[IMMW-1]}}, imm_i};
    endcase
  end

  assign opnd_b_o = use_imm_i ? imm_ext : reg_b_i;
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  val_o
);
  logic [W-1:0] stage [AW+1];
  logic         fill;

  assign fill     = arith_i & val_i[W-1];
  assign stage[0] = val_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] shl, shr;
    assign shl = {stage[k][W-1-S:0], {S{1'b0}}};
    assign shr = {{S{fill}}, stage[k][W-1:S]};
    assign stage[k+1] = !amt_i[k] ? stage[k] : (left_i ? shl : shr);
  end

  assign val_o = stage[AW];
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_raw_o
);
  logic [XLEN-1:0] sum, diff, shifted;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;

  iexu_shift #(.W(XLEN), .AW(SHW)) u_shift (
    .val_i   (b_i),
    .amt_i   (shamt_i),
    .left_i  (op_i == ALU_SLL),
    .arith_i (op_i == ALU_SRA),
    .val_o   (shifted)
  );

  always_comb begin
    ovf_raw_o = 1'b0;
    case (op_i)
      ALU_ADD:  begin res_o = sum;  ovf_raw_o = add_overflows(a_i, b_i, sum);  end
      ALU_SUB:  begin res_o = diff; ovf_raw_o = sub_overflows(a_i, b_i, diff); end
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_NOR:  res_o = ~(a_i | b_i);
      ALU_SLT:  res_o = {{(XLEN-1){1'b0}}, signed_less(a_i, b_i)};
      ALU_SLTU: res_o = {{(XLEN-1){1'b0}}, (a_i < b_i)};
      ALU_SLL, ALU_SRL, ALU_SRA: res_o = shifted;
      default:  res_o = b_i;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [31:0] src_a_i,
  input  logic [31:0] src_b_i,
  output logic [31:0] result_o,
  output logic [4:0]  dest_idx_o,
  output logic        wr_en_o,
  output logic        ovf_trap_o,
  output logic        bad_op_o
);
  ctl_t            ctl;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_res;
  logic            ovf_raw;

  iexu_decode u_dec (.instr_i(instr_i), .ctl_o(ctl));

  iexu_operand u_opnd (
    .imm_i     (instr_i[IMMW-1:0]),
    .ext_i     (ctl.ext),
    .use_imm_i (ctl.use_imm),
    .reg_b_i   (src_b_i),
    .opnd_b_o  (opnd_b)
  );

  iexu_alu u_alu (
    .op_i      (ctl.op),
    .a_i       (src_a_i),
    .b_i       (opnd_b),
    .shamt_i   (instr_i[SH_LSB +: SHW]),
    .res_o     (alu_res),
    .ovf_raw_o (ovf_raw)
  );

  assign dest_idx_o = ctl.dst_is_rd ? instr_i[RD_LSB +: REGW] : instr_i[RT_LSB +: REGW];
  assign ovf_trap_o = ovf_raw & ctl.trap_en & ~ctl.reserved;
  assign bad_op_o   = ctl.reserved;
  assign wr_en_o    = ~ctl.reserved & ~ovf_trap_o;
  assign result_o   = ctl.reserved ? '0 : alu_res;
endmodule

// File: rtl/iexu_checker.sv
module iexu_checker (
  input logic [31:0] instr_i,
  input logic [31:0] src_b_i,
  input logic [31:0] result_o,
  input logic [4:0]  dest_idx_o,
  input logic        wr_en_o,
  input logic        ovf_trap_o,
  input logic        bad_op_o,
  input logic [31:0] opnd_b,
  input logic        ovf_raw
);
  logic [5:0] opc, fn;
  assign opc = instr_i[31:26];
  assign fn  = instr_i[5:0];

  always_comb begin
    // R4
    trap_blocks_write_chk: assert (!(ovf_trap_o === 1'b1 && wr_en_o === 1'b1));
    // R10
    bad_op_quiet_chk: assert (!(bad_op_o === 1'b1 && (wr_en_o !== 1'b0 || ovf_trap_o !== 1'b0)));
    // R3
    if (ovf_trap_o === 1'b1)
      trap_source_chk: assert ((opc == 6'h00 && (fn == 6'h20 || fn == 6'h22)) || opc == 6'h08);
    // R3
    if (ovf_trap_o === 1'b1)
      trap_raw_chk: assert (ovf_raw === 1'b1);
    // R1
    if (wr_en_o === 1'b1)
      dest_field_chk: assert (dest_idx_o == ((opc == 6'h00) ? instr_i[15:11] : instr_i[20:16]));
    // R6
    if (wr_en_o === 1'b1 && ((opc == 6'h00 && (fn == 6'h2a || fn == 6'h2b)) || opc == 6'h0a || opc == 6'h0b))
      cmp_boolean_chk: assert (result_o[31:1] == 31'd0);
    // R8
    if (wr_en_o === 1'b1 && opc == 6'h0f)
      upper_imm_chk: assert (result_o == {instr_i[15:0], 16'h0000});
    // R5
    if (wr_en_o === 1'b1 && (opc == 6'h0c || opc == 6'h0d))
      zero_ext_chk: assert (opnd_b[31:16] == 16'h0000);
    // R7
    if (wr_en_o === 1'b1 && opc == 6'h00 && fn == 6'h03)
      sra_sign_chk: assert (result_o[31] == src_b_i[31]);
  end
endmodule

bind int_exec_unit iexu_checker u_chk (
  .instr_i    (instr_i),
  .src_b_i    (src_b_i),
  .result_o   (result_o),
  .dest_idx_o (dest_idx_o),
  .wr_en_o    (wr_en_o),
  .ovf_trap_o (ovf_trap_o),
  .bad_op_o   (bad_op_o),
  .opnd_b     (opnd_b),
  .ovf_raw    (ovf_raw)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
  logic        clk = 1'b0;
  logic [31:0] instr, a, b;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        we, ovf, bad;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  int_exec_unit dut (
    .instr_i(instr), .src_a_i(a), .src_b_i(b),
    .result_o(result), .dest_idx_o(dest), .wr_en_o(we),
    .ovf_trap_o(ovf), .bad_op_o(bad)
  );

  function automatic logic fits32(input longint v);
    return (v <= 64'sd2147483647) && (v >= -64'sd2147483648);
  endfunction

  function automatic void model(input logic [31:0] ins, input logic [31:0] x, input logic [31:0] y,
                                output logic [31:0] r, output logic [4:0] d,
                                output logic w, output logic o, output logic z);
    logic [5:0] opc = ins[31:26];
    logic [5:0] fn  = ins[5:0];
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] zx = {16'h0, ins[15:0]};
    int sh = int'(ins[10:6]);
    r = '0; o = 1'b0; z = 1'b0;
    d = (opc == 6'h00) ? ins[15:11] : ins[20:16];
    if (opc == 6'h00) begin
      case (fn)
        6'h20: begin r = x + y; o = !fits32(longint'($signed(x)) + longint'($signed(y))); end
        6'h21: r = x + y;
        6'h22: begin r = x - y; o = !fits32(longint'($signed(x)) - longint'($signed(y))); end
        6'h23: r = x - y;
        6'h24: r = x & y;
        6'h25: r = x | y;
        6'h27: r = ~(x | y);
        6'h2a: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        6'h2b: r = (x < y) ? 32'd1 : 32'd0;
        6'h00: r = y << sh;
        6'h02: r = y >> sh;
        6'h03: r = 32'($signed(y) >>> sh);
        default: z = 1'b1;
      endcase
    end else begin
      case (opc)
        6'h08: begin r = x + sx; o = !fits32(longint'($signed(x)) + longint'($signed(sx))); end
        6'h09: r = x + sx;
        6'h0a: r = ($signed(x) < $signed(sx)) ? 32'd1 : 32'd0;
        6'h0b: r = (x < sx) ? 32'd1 : 32'd0;
        6'h0c: r = x & zx;
        6'h0d: r = x | zx;
        6'h0f: r = {ins[15:0], 16'h0};
        default: z = 1'b1;
      endcase
    end
    w = !z && !o;
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    logic [5:0] opc = ins[31:26];
    logic [5:0] fn  = ins[5:0];
    if (opc == 6'h00) begin
      case (fn)
        6'h20, 6'h21, 6'h22, 6'h23: return "R2";
        6'h24, 6'h25, 6'h27: return "R5";
        6'h2a, 6'h2b: return "R6";
        6'h00, 6'h02, 6'h03: return "R7";
        default: return "R10";
      endcase
    end
    case (opc)
      6'h08, 6'h09: return "R9";
      6'h0a, 6'h0b: return "R6";
      6'h0c, 6'h0d: return "R5";
      6'h0f: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (instr %h a %h b %h)", tag, what, act, exp, instr, a, b);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er; logic [4:0] ed; logic ew, eo, ez;
    model(ins, x, y, er, ed, ew, eo, ez);
    @(negedge clk);
    instr = ins; a = x; b = y;
    @(posedge clk); #1;
    cmp(tag_of(ins), "result", result, er);
    cmp("R1", "dest", {27'd0, dest}, {27'd0, ed});
    cmp("R3", "ovf", {31'd0, ovf}, {31'd0, eo});
    cmp(eo ? "R4" : "R11", "wr_en", {31'd0, we}, {31'd0, ew});
    cmp("R10", "bad_op", {31'd0, bad}, {31'd0, ez});
  endtask

  function automatic logic [31:0] rr(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] sh);
    return {6'h00, 5'd3, 5'd4, rd, sh, fn};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] opc, input logic [4:0] rt, input logic [15:0] imm);
    return {opc, 5'd7, rt, imm};
  endfunction

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h7fff_ffff;
      1: return 32'h8000_0000;
      2: return 32'h0000_0000;
      3: return 32'hffff_ffff;
      4: return 32'h7fff_0000 + $urandom_range(0, 65535);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    instr = 32'h0; a = 32'h0; b = 32'h0;
    // reset-like idle word: sll of zero is a recognised op (R7/R11)
    run(32'h0000_0000, 32'h0, 32'h0);
    // R3 / R4: trapping add overflow vs non-trapping twin
    run(rr(6'h20, 5'd9, 5'd0), 32'h7fff_ffff, 32'h1);
    run(rr(6'h21, 5'd9, 5'd0), 32'h7fff_ffff, 32'h1);
    run(rr(6'h22, 5'd10, 5'd0), 32'h8000_0000, 32'h1);
    run(rr(6'h23, 5'd10, 5'd0), 32'h8000_0000, 32'h1);
    run(rr(6'h20, 5'd9, 5'd0), 32'h8000_0000, 32'h8000_0000);
    run(rr(6'h22, 5'd9, 5'd0), 32'h0, 32'h8000_0000);
    // R9 / R3: immediate add wrap points
    run(ri(6'h08, 5'd11, 16'h0001), 32'h7fff_ffff, 32'h0);
    run(ri(6'h09, 5'd11, 16'h0001), 32'h7fff_ffff, 32'h0);
    run(ri(6'h08, 5'd12, 16'hffff), 32'h8000_0000, 32'h0);
    run(ri(6'h08, 5'd12, 16'h8000), 32'h0000_0010, 32'h0);
    // R6: signed vs unsigned compare, sign-extended immediate
    run(rr(6'h2a, 5'd1, 5'd0), 32'hffff_ffff, 32'h1);
    run(rr(6'h2b, 5'd1, 5'd0), 32'hffff_ffff, 32'h1);
    run(ri(6'h0b, 5'd2, 16'hffff), 32'h0000_0005, 32'h0);
    run(ri(6'h0a, 5'd2, 16'hffff), 32'h0000_0005, 32'h0);
    // R7: shifts of a negative value
    run(rr(6'h03, 5'd5, 5'd4), 32'h0, 32'h8000_00f0);
    run(rr(6'h02, 5'd5, 5'd4), 32'h0, 32'h8000_00f0);
    run(rr(6'h00, 5'd5, 5'd31), 32'h0, 32'h0000_0003);
    run(rr(6'h03, 5'd5, 5'd31), 32'h0, 32'h8000_0000);
    // R5: zero extension of logic immediates
    run(ri(6'h0c, 5'd6, 16'hf00f), 32'hffff_ffff, 32'h0);
    run(ri(6'h0d, 5'd6, 16'h8001), 32'h0000_0000, 32'h0);
    run(rr(6'h27, 5'd6, 5'd0), 32'h0f0f_0000, 32'h0000_00ff);
    // R8: upper immediate ignores operands
    run(ri(6'h0f, 5'd8, 16'hbeef), 32'h1234_5678, 32'h9abc_def0);
    // R10: reserved function and opcode
    run(rr(6'h01, 5'd13, 5'd0), 32'h7fff_ffff, 32'h1);
    run(rr(6'h18, 5'd13, 5'd0), 32'h5, 32'h6);
    run(ri(6'h3f, 5'd14, 16'h1234), 32'h5, 32'h6);
    run(ri(6'h0e, 5'd14, 16'h1234), 32'h5, 32'h6);
    // constrained random
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] ins;
      logic [5:0]  code;
      int k = $urandom_range(0, 20);
      ins = $urandom;
      if (k < 12) begin
        case (k)
          0: code = 6'h20;  1: code = 6'h21;  2: code = 6'h22;  3: code = 6'h23;
          4: code = 6'h24;  5: code = 6'h25;  6: code = 6'h27;  7: code = 6'h2a;
          8: code = 6'h2b;  9: code = 6'h00;  10: code = 6'h02; default: code = 6'h03;
        endcase
        ins[31:26] = 6'h00;
        ins[5:0] = code;
      end else if (k < 19) begin
        case (k)
          12: code = 6'h08; 13: code = 6'h09; 14: code = 6'h0a; 15: code = 6'h0b;
          16: code = 6'h0c; 17: code = 6'h0d; default: code = 6'h0f;
        endcase
        ins[31:26] = code;
      end
      run(ins, pick_val(), pick_val());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule